// File: doc/BRIEF.md
# Daisy-Chain Converter Serial Output Port

This block is the digital serial side of one 16-bit converter that can be wired in a chain with identical devices. A host drives a conversion-start line, a serial clock and a serial data input. The data input of each device is tied to the data output of the device before it. The block runs entirely on a system clock. It synchronises the three host pins and detects their edges. It times the conversion with a fixed count of system-clock cycles, and it latches the parallel result offered by the converter core when that count expires.

A rising edge of the start line while the serial input is low begins a conversion. The level of the serial clock at that moment picks one of two readout forms. If the clock is high, the output goes high when the conversion ends, which gives the host an interrupt edge, and the data follows on later falling clock edges. If the clock is low, the output shows the most significant result bit at once. Each detected falling edge of the serial clock moves the next bit onto the output and captures the serial input into the shift register. Upstream words therefore appear on the output after the local word.

When the busy form is active, the first falling edge captures nothing. This drops the upstream device's busy bit from the chain. Lowering the start line at any time returns the block to acquisition, where the output is held low.

Top module: `adc_dc_port`

## Requirements
- R1: After reset, `sdo` is 0 and `converting` is 0.
- R2: Whenever the block is neither converting nor reading out (acquisition, including when `cnv` and `sdi` are both low), `sdo` is 0.
- R3: A rising edge on `cnv` while `sdi` is low starts a conversion. `converting` is then high for exactly CONV_CYCLES system-clock cycles. A rising edge on `cnv` while `sdi` is high starts nothing, and `converting` stays 0.
- R4: Toggling `sck` during a conversion changes neither the conversion length nor the result that is read out.
- R5: If `sck` is high at the `cnv` rising edge, `sdo` is 1 right after the conversion ends. If `sck` is low, `sdo` is bit 15 of the result right after the conversion ends.
- R6: The result is read out MSB first, one bit per detected `sck` falling edge. In the busy form, the first falling edge brings bit 15, and falling edge k+1 brings bit 15-k.
- R7: After the 16 local bits, `sdo` presents the `sdi` values captured on the falling edges, in capture order. In the busy form, the `sdi` value at the first falling edge is discarded, so an upstream busy bit is not forwarded.
- R8: `cnv` falling during a conversion or a readout returns the block to acquisition: `converting` goes to 0, `sdo` goes to 0, and no result appears later.
- R9: `conv_result` is sampled in the cycle the conversion ends. Later changes to it do not alter the bits read out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnv | input | 1 | Conversion start; must stay high through readout |
| sck | input | 1 | Serial clock from the host, asynchronous |
| sdi | input | 1 | Serial input from the upstream device in the chain |
| conv_result | input | RES_W | Parallel result from the converter core |
| sdo | output | 1 | Serial output toward the next device or the host |
| converting | output | 1 | High while the conversion timer runs |

## Verification
Two events can fall in the same system cycle: a falling edge of `sck` and the expiry of the conversion timer. Toggling `sck` during a conversion is meant to show that the timer alone ends the conversion and that no falling edge shifts the register while the timer runs. The bench toggles `sck` throughout several conversions, with the last toggle kept clear of the end of the conversion. It judges the result by the exact count of `converting` cycles and by the full bit sequence read afterwards. A second collision is a `cnv` fall arriving while an output bit is high. The bench lowers `cnv` right after a result with bit 15 set and checks that `sdo` drops and stays low.

// File: rtl/adc_dc_pkg.sv
package adc_dc_pkg;

    typedef enum logic [1:0] {
        PH_ACQ  = 2'd0,
        PH_CONV = 2'd1,
        PH_READ = 2'd2
    } phase_e;

    typedef struct packed {
        phase_e phase;
        logic   busy_en;   // busy form selected at start
        logic   skip;      // next falling edge only reveals MSB
        logic   sdo;
        logic   cnv_p;     // previous synchronised cnv
        logic   sck_p;     // previous synchronised sck
    } port_st_t;

endpackage

// File: rtl/adc_dc_sync.sv
module adc_dc_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] pipe_d [STAGES];
    logic [WIDTH-1:0] pipe_q [STAGES];

    always_comb pipe_d[0] = din;

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_comb pipe_d[s] = pipe_q[s-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) pipe_q[s] <= '0;
        end else begin
            for (int s = 0; s < STAGES; s++) pipe_q[s] <= pipe_d[s];
        end
    end

    assign dout = pipe_q[STAGES-1];
endmodule

// File: rtl/adc_dc_timer.sv
module adc_dc_timer #(
    parameter int CONV_CYCLES = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic abort,
    output logic running,
    output logic done
);
    localparam int CNT_W = $clog2(CONV_CYCLES + 1);
    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(CONV_CYCLES - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic             run_d, run_q;

    assign done    = run_q && (cnt_q == '0);
    assign running = run_q;

    always_comb begin
        cnt_d = cnt_q;
        run_d = run_q;
        if (abort) begin
            run_d = 1'b0;
            cnt_d = '0;
        end else if (start) begin
            run_d = 1'b1;
            cnt_d = LOAD_VAL;
        end else if (run_q) begin
            if (cnt_q == '0) run_d = 1'b0;
            else             cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            run_q <= run_d;
        end
    end
endmodule

// File: rtl/adc_dc_shift.sv
module adc_dc_shift #(
    parameter int RES_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [RES_W-1:0] load_val,
    input  logic             shift,
    input  logic             ser_in,
    output logic [RES_W-1:0] word
);
    logic [RES_W-1:0] word_d, word_q;

    always_comb begin
        word_d = word_q;
        if (load)       word_d = load_val;
        else if (shift) word_d = {word_q[RES_W-2:0], ser_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) word_q <= '0;
        else        word_q <= word_d;
    end

    assign word = word_q;
endmodule

// File: rtl/adc_dc_port.sv
module adc_dc_port
    import adc_dc_pkg::*;
#(
    parameter int RES_W       = 16,
    parameter int CONV_CYCLES = 40,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnv,
    input  logic             sck,
    input  logic             sdi,
    input  logic [RES_W-1:0] conv_result,
    output logic             sdo,
    output logic             converting
);
    localparam int MSB = RES_W - 1;

    logic [2:0]       pins_s;
    logic             cnv_s, sck_s, sdi_s;
    logic             cnv_rise, sck_fall;
    logic             tmr_start, tmr_abort, tmr_running, tmr_done;
    logic             sr_load, sr_shift;
    logic [RES_W-1:0] sr_q;
    logic             in_read, busy_en, skip;
    port_st_t         st_d, st_q;

    adc_dc_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({cnv, sck, sdi}),
        .dout (pins_s)
    );
    assign cnv_s = pins_s[2];
    assign sck_s = pins_s[1];
    assign sdi_s = pins_s[0];

    assign cnv_rise = cnv_s & ~st_q.cnv_p;
    assign sck_fall = ~sck_s & st_q.sck_p;

    assign tmr_start = (st_q.phase == PH_ACQ) & cnv_rise & ~sdi_s;
    assign tmr_abort = (st_q.phase == PH_CONV) & ~cnv_s;
    assign sr_load   = (st_q.phase == PH_CONV) & cnv_s & tmr_done;
    assign sr_shift  = (st_q.phase == PH_READ) & cnv_s & sck_fall & ~st_q.skip;

    adc_dc_timer #(.CONV_CYCLES(CONV_CYCLES)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (tmr_start),
        .abort  (tmr_abort),
        .running(tmr_running),
        .done   (tmr_done)
    );

    adc_dc_shift #(.RES_W(RES_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (sr_load),
        .load_val(conv_result),
        .shift   (sr_shift),
        .ser_in  (sdi_s),
        .word    (sr_q)
    );

    always_comb begin
        st_d       = st_q;
        st_d.cnv_p = cnv_s;
        st_d.sck_p = sck_s;
        unique case (st_q.phase)
            PH_ACQ: begin
                st_d.sdo = 1'b0;
                if (tmr_start) begin
                    st_d.phase   = PH_CONV;
                    st_d.busy_en = sck_s;
                    st_d.skip    = sck_s;
                end
            end
            PH_CONV: begin
                st_d.sdo = 1'b0;
                if (!cnv_s) begin
                    st_d.phase   = PH_ACQ;
                    st_d.busy_en = 1'b0;
                    st_d.skip    = 1'b0;
                end else if (tmr_done) begin
                    st_d.phase = PH_READ;
                    st_d.sdo   = st_q.busy_en ? 1'b1 : conv_result[MSB];
                end
            end
            PH_READ: begin
                if (!cnv_s) begin
                    st_d.phase   = PH_ACQ;
                    st_d.sdo     = 1'b0;
                    st_d.busy_en = 1'b0;
                    st_d.skip    = 1'b0;
                end else if (sck_fall) begin
                    if (st_q.skip) begin
                        st_d.skip = 1'b0;
                        st_d.sdo  = sr_q[MSB];
                    end else begin
                        st_d.sdo  = sr_q[MSB-1];
                    end
                end
            end
            default: begin
                st_d.phase = PH_ACQ;
                st_d.sdo   = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_ACQ, default: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign sdo        = st_q.sdo;
    assign converting = (st_q.phase == PH_CONV);
    assign in_read    = (st_q.phase == PH_READ);
    assign busy_en    = st_q.busy_en;
    assign skip       = st_q.skip;
endmodule

// File: rtl/adc_dc_port_chk.sv
module adc_dc_port_chk #(
    parameter int RES_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sdo,
    input logic             converting,
    input logic             in_read,
    input logic             busy_en,
    input logic             skip,
    input logic             cnv_s,
    input logic             sdi_s,
    input logic             cnv_rise,
    input logic             sck_fall,
    input logic             tmr_running,
    input logic [RES_W-1:0] sr_q
);
    assert_idle_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!converting && !in_read) |-> !sdo);

    assert_start_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(converting) |-> $past(cnv_rise));

    assert_timer_active_R3: assert property (@(posedge clk) disable iff (!rst_n)
        converting |-> tmr_running);

    assert_sr_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (converting && $past(converting)) |-> $stable(sr_q));

    assert_busy_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(converting) && in_read && busy_en) |-> sdo);

    assert_shift_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_read && cnv_s && sck_fall && !skip) |=>
            (sr_q == {$past(sr_q[RES_W-2:0]), $past(sdi_s)}));

    assert_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((converting || in_read) && !cnv_s) |=> (!converting && !in_read));
endmodule

bind adc_dc_port adc_dc_port_chk #(.RES_W(RES_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sdo        (sdo),
    .converting (converting),
    .in_read    (in_read),
    .busy_en    (busy_en),
    .skip       (skip),
    .cnv_s      (cnv_s),
    .sdi_s      (sdi_s),
    .cnv_rise   (cnv_rise),
    .sck_fall   (sck_fall),
    .tmr_running(tmr_running),
    .sr_q       (sr_q)
);

// File: tb/adc_dc_port_test.sv
module adc_dc_port_test;
    localparam int CONV = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnv = 1'b0, sck = 1'b0, sdi = 1'b0;
    logic [15:0] conv_result = '0;
    logic        sdo, converting;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;   // 125 MHz

    adc_dc_port #(.RES_W(16), .CONV_CYCLES(CONV), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst_n(rst_n), .cnv(cnv), .sck(sck), .sdi(sdi),
        .conv_result(conv_result), .sdo(sdo), .converting(converting)
    );

    // {busy form, toggle sck in conversion, result, upstream word}
    localparam logic [33:0] VEC [4] = '{
        {1'b1, 1'b0, 16'hA5C3, 16'h3C96},
        {1'b0, 1'b1, 16'h8001, 16'hFFFE},
        {1'b1, 1'b1, 16'h7FFE, 16'h0001},
        {1'b0, 1'b0, 16'h1234, 16'hCAFE}
    };

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(int n);
        repeat (n) @(negedge clk);
    endtask

    // start a conversion; return number of cycles converting was high
    task automatic run_conv(input logic busy, input logic toggle, output int cycles);
        int guard = 0;
        sck = busy;
        sdi = 1'b0;
        wait_clk(4);
        cnv = 1'b1;
        while (!converting && guard < 20) begin
            guard++;
            wait_clk(1);
        end
        cycles = 0;
        while (converting && cycles < 1000) begin
            cycles++;
            if (toggle && (cycles % 3 == 0) && cycles < CONV - 6) sck = ~sck;
            wait_clk(1);
        end
    endtask

    task automatic fall_edge();
        if (!sck) begin
            sck = 1'b1;
            wait_clk(4);
        end
        sck = 1'b0;
        wait_clk(6);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        int cyc;
        wait_clk(3);
        check("R1 sdo", sdo, 0);
        check("R1 converting", converting, 0);
        rst_n = 1'b1;
        wait_clk(5);

        // R2: acquisition with low and high sdi
        check("R2 cnv low sdi low", sdo, 0);
        sdi = 1'b1;
        wait_clk(6);
        check("R2 cnv low sdi high", sdo, 0);

        // R3: cnv rise with sdi high starts nothing
        cnv = 1'b1;
        wait_clk(CONV + 10);
        check("R3 no start with sdi high", converting, 0);
        check("R2 sdo after refused start", sdo, 0);
        cnv = 1'b0;
        sdi = 1'b0;
        wait_clk(6);

        // vector walk: R3 R4 R5 R6 R7 R9
        for (int v = 0; v < 4; v++) begin
            logic        busy, tog;
            logic [15:0] res, up;
            logic        outs [33];
            logic        seq  [34];
            int          len;
            {busy, tog, res, up} = VEC[v];
            len = busy ? 33 : 32;
            for (int i = 0; i < 34; i++) seq[i] = 1'b0;
            for (int i = 0; i < 33; i++) outs[i] = 1'b0;
            if (busy) begin
                seq[0]  = 1'b1;
                outs[0] = 1'b1;
                for (int i = 0; i < 16; i++) begin
                    seq[1+i]   = up[15-i];
                    outs[1+i]  = res[15-i];
                    outs[17+i] = up[15-i];
                end
            end else begin
                for (int i = 0; i < 16; i++) begin
                    seq[i]     = up[15-i];
                    outs[i]    = res[15-i];
                    outs[16+i] = up[15-i];
                end
            end
            conv_result = res;
            run_conv(busy, tog, cyc);
            check(tog ? "R4 length with sck toggling" : "R3 conversion length", cyc, CONV);
            conv_result = ~res;    // R9: later change must not matter
            sdi = seq[0];
            wait_clk(2);
            check("R5 sdo at conversion end", sdo, outs[0]);
            for (int k = 1; k < len; k++) begin
                fall_edge();
                if (k <= 16) check(busy ? "R6 busy-form bit" : "R6 local bit", sdo, outs[k]);
                else         check(busy ? "R7 forwarded bit, busy absorbed" : "R7 forwarded bit", sdo, outs[k]);
                sdi = seq[k];
            end
            cnv = 1'b0;
            sdi = 1'b0;
            wait_clk(6);
            check("R2 sdo after readout", sdo, 0);
        end

        // R8: abort during conversion
        conv_result = 16'hFFFF;
        sck = 1'b1;
        wait_clk(4);
        cnv = 1'b1;
        wait_clk(12);
        check("R8 converting before abort", converting, 1);
        cnv = 1'b0;
        wait_clk(6);
        check("R8 converting after abort", converting, 0);
        check("R8 sdo after abort", sdo, 0);
        wait_clk(CONV + 10);
        check("R8 no late result", sdo, 0);

        // R8: abort during readout while sdo high
        conv_result = 16'h8000;
        run_conv(1'b0, 1'b0, cyc);
        check("R3 length after abort", cyc, CONV);
        wait_clk(2);
        check("R5 msb shown without busy", sdo, 1);
        cnv = 1'b0;
        wait_clk(6);
        check("R8 sdo after readout abort", sdo, 0);
        check("R8 converting after readout abort", converting, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule